// File: doc/BRIEF.md
# I2C EEPROM Write Slave Engine

This block is the slave side of a two-wire serial memory for write transfers only. It oversamples the serial clock and data lines with the system clock. It finds start and stop conditions on the bus and shifts in the device byte. If the device byte matches the configured 7-bit address and asks for a write, the block collects a 16-bit memory address, sent high byte first. It then hands each following data byte to a page buffer, together with the address where that byte belongs.

The block acknowledges each byte it accepts by asserting `sda_oe`. The pad outside the block turns `sda_oe` into an open-drain low on the data line. A stop condition that ends a transfer carrying data raises a one-cycle `prog_start` to the memory array. While the array reports `prog_busy`, the block does not acknowledge its own device byte. A bus master can therefore poll with repeated write headers until an acknowledge comes back.

Top module: `i2c_eeprom_wr_slave`

## Requirements
- R1: While reset is asserted and immediately after it, `sda_oe`, `wr_valid` and `prog_start` are all 0.
- R2: A device byte whose upper seven bits equal `dev_addr` and whose last bit (the direction bit) is 0 is acknowledged: `sda_oe` is 1 throughout the ninth SCL high phase. This applies only when `prog_busy` is 0 at the falling SCL edge that ends the eighth bit.
- R3: If a device byte carries a different address, or carries a direction bit of 1, it gets no acknowledge. The block then drives nothing, writes nothing and acknowledges no further byte until the next start condition.
- R4: If `prog_busy` is 1 when the device byte completes, that byte gets no acknowledge. Once `prog_busy` has returned to 0, a fresh start and matching write header are acknowledged again.
- R5: After the device byte, two address bytes follow: the high byte (address bits 15..8) first, then the low byte. Both are acknowledged.
- R6: Every data byte after the address bytes is acknowledged. Each one produces a one-cycle `wr_valid`, with `wr_data` holding the byte shifted in MSB first and `wr_addr` holding its address.
- R7: After each data byte, the lowest PAGE_BITS bits of the address count up by one and wrap to zero within the page. The higher bits never change.
- R8: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. A stop that follows at least one accepted data byte gives exactly one one-cycle `prog_start` pulse. A stop after a transfer with no data byte gives none.
- R9: A start condition in the middle of a transfer clears the bit count and returns the block to device-byte reception. The transfer that follows is handled as a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| dev_addr | input | 7 | Configured 7-bit device address |
| prog_busy | input | 1 | Memory array is running a program cycle |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 16 | Memory address of the strobed byte |
| wr_data | output | 8 | Received data byte |
| prog_start | output | 1 | One-cycle pulse that starts programming |

## Verification
Two things can happen in the same clock cycle: the busy input from the array changes, and the block decides whether to acknowledge the device byte. The block looks at `prog_busy` only at the SCL fall that ends the eighth bit. The bench therefore lowers busy while the device byte is still being shifted in, and expects an acknowledge. It also holds busy high across that fall and expects none. In both cases the bench judges the result from the level of the data line in the ninth SCL high phase.

// File: rtl/i2c_eeprom_wr_slave.sv
module i2c_eeprom_wr_slave #(
  parameter int PAGE_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [6:0]  dev_addr,
  input  logic        prog_busy,
  output logic        sda_oe,
  output logic        wr_valid,
  output logic [15:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        prog_start
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA} st_t;

  st_t         state;
  logic [1:0]  scl_sy, sda_sy;
  logic        scl_q, sda_q;
  logic [3:0]  bitcnt;
  logic        ack_ph, got_data;
  logic [7:0]  shreg;
  logic [15:0] addr;

  wire scl_s  = scl_sy[1];
  wire sda_s  = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire byte_done = fall && bitcnt == 4'd8 && !ack_ph && state != S_IDLE;
  wire dev_ok  = shreg[7:1] == dev_addr && !shreg[0] && !prog_busy;
  wire [PAGE_BITS-1:0] pg_nx = addr[PAGE_BITS-1:0] + PAGE_BITS'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bitcnt     <= '0;
      ack_ph     <= 1'b0;
      got_data   <= 1'b0;
      shreg      <= '0;
      addr       <= '0;
      sda_oe     <= 1'b0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      prog_start <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      prog_start <= 1'b0;
      if (start_c) begin
        state    <= S_DEV;
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (stop_c) begin
        prog_start <= state == S_DATA && got_data;
        state      <= S_IDLE;
        bitcnt     <= '0;
        ack_ph     <= 1'b0;
        sda_oe     <= 1'b0;
        got_data   <= 1'b0;
      end else if (state != S_IDLE) begin
        if (rise && !ack_ph && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (byte_done) begin
          ack_ph <= 1'b1;
          bitcnt <= '0;
          case (state)
            S_DEV: begin
              sda_oe <= dev_ok;
              state  <= dev_ok ? S_AHI : S_IDLE;
            end
            S_AHI: begin
              sda_oe      <= 1'b1;
              addr[15:8]  <= shreg;
              state       <= S_ALO;
            end
            S_ALO: begin
              sda_oe     <= 1'b1;
              addr[7:0]  <= shreg;
              state      <= S_DATA;
            end
            default: begin
              sda_oe   <= 1'b1;
              wr_valid <= 1'b1;
              wr_addr  <= addr;
              wr_data  <= shreg;
              got_data <= 1'b1;
              addr     <= {addr[15:PAGE_BITS], pg_nx};
            end
          endcase
        end else if (fall && ack_ph) begin
          ack_ph <= 1'b0;
          sda_oe <= 1'b0;
        end
      end
    end
  end

  a_r1_no_drive_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_oe);
  a_r2_drive_only_in_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ack_ph);
  a_r4_busy_blocks_dev_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == S_DEV && prog_busy) |=> !sda_oe);
  a_r3_mismatch_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == S_DEV && !start_c && !stop_c && shreg[7:1] != dev_addr) |=> state == S_IDLE);
  a_r7_page_high_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && $past(state) == S_DATA) |-> addr[15:PAGE_BITS] == $past(addr[15:PAGE_BITS]));
  a_r8_prog_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

endmodule

// File: tb/i2c_eeprom_wr_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_wr_slave_test;
  localparam int H = 10;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, prog_busy = 1'b0;
  logic sda_oe, wr_valid, prog_start;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, nwr = 0, nprog = 0;
  logic [15:0] cap_addr [0:31];
  logic [7:0]  cap_data [0:31];

  always #2.5 clk = ~clk;

  i2c_eeprom_wr_slave #(.PAGE_BITS(5)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_addr(DEV), .prog_busy(prog_busy), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start));

  always @(negedge clk) begin
    if (wr_valid && nwr < 32) begin
      cap_addr[nwr] = wr_addr;
      cap_data[nwr] = wr_data;
      nwr++;
    end
    if (prog_start) nprog++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(2*H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2);
    ack = !sda_line;
    tick(H/2); scl_m = 1'b0;
  endtask

  task automatic t_reset();
    check(!sda_oe && !wr_valid && !prog_start, "R1 outputs in reset", {sda_oe, wr_valid, prog_start}, 0);
    tick(3); rst_n = 1'b1; tick(2);
    check(!sda_oe && !wr_valid && !prog_start, "R1 outputs after reset", {sda_oe, wr_valid, prog_start}, 0);
  endtask

  task automatic t_single();
    bit a; int w0 = nwr, p0 = nprog;
    bus_start();
    send_byte({DEV, 1'b0}, a); check(a, "R2 device ack", a, 1);
    send_byte(8'h12, a);       check(a, "R5 high address ack", a, 1);
    send_byte(8'h34, a);       check(a, "R5 low address ack", a, 1);
    send_byte(8'hA5, a);       check(a, "R6 data ack", a, 1);
    bus_stop();
    check(nwr == w0 + 1, "R6 one strobe", nwr - w0, 1);
    check(cap_addr[w0] == 16'h1234, "R5 address order", cap_addr[w0], 16'h1234);
    check(cap_data[w0] == 8'hA5, "R6 data MSB first", cap_data[w0], 8'hA5);
    check(nprog == p0 + 1, "R8 program pulse on stop", nprog - p0, 1);
  endtask

  task automatic t_poll();
    bit a; int p0 = nprog;
    prog_busy = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, a); check(!a, "R4 busy nack", a, 0);
    bus_stop();
    fork
      send_byte({DEV, 1'b0}, a);
      begin tick(5*2*H); prog_busy = 1'b0; end
    join
    check(a == 1'b0, "R4 held until start", a, 0);
    prog_busy = 1'b0;
    bus_start();
    prog_busy = 1'b1;
    fork
      send_byte({DEV, 1'b0}, a);
      begin tick(6*2*H); prog_busy = 1'b0; end
    join
    check(a, "R4 ack once busy cleared before decision", a, 1);
    bus_stop();
    check(nprog == p0, "R8 no program without data", nprog - p0, 0);
  endtask

  task automatic t_mismatch();
    bit a; int w0 = nwr;
    bus_start();
    send_byte({7'h51, 1'b0}, a); check(!a, "R3 wrong address nack", a, 0);
    send_byte(8'h00, a);         check(!a, "R3 ignored after mismatch", a, 0);
    send_byte(8'h77, a);         check(!a, "R3 still ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, a);   check(!a, "R3 read direction nack", a, 0);
    bus_stop();
    check(nwr == w0, "R3 no write strobes", nwr - w0, 0);
  endtask

  task automatic t_page();
    bit a; int w0 = nwr, p0 = nprog;
    logic [15:0] exp_a [4] = '{16'h123E, 16'h123F, 16'h1220, 16'h1221};
    logic [7:0]  dat   [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h12, a);
    send_byte(8'h3E, a);
    for (int i = 0; i < 4; i++) begin
      send_byte(dat[i], a); check(a, "R6 page data ack", a, 1);
    end
    bus_stop();
    check(nwr == w0 + 4, "R6 four strobes", nwr - w0, 4);
    for (int i = 0; i < 4; i++) begin
      check(cap_addr[w0+i] == exp_a[i], "R7 page wrap address", cap_addr[w0+i], exp_a[i]);
      check(cap_data[w0+i] == dat[i], "R6 page data", cap_data[w0+i], dat[i]);
    end
    check(nprog == p0 + 1, "R8 single program pulse", nprog - p0, 1);
  endtask

  task automatic t_rstart();
    bit a; int w0 = nwr;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h55, a);
    bus_start();
    send_byte({DEV, 1'b0}, a); check(a, "R9 device ack after repeated start", a, 1);
    send_byte(8'h00, a);
    send_byte(8'h10, a);
    send_byte(8'h5A, a);       check(a, "R9 data ack", a, 1);
    bus_stop();
    check(nwr == w0 + 1 && cap_addr[w0] == 16'h0010, "R9 new address used", cap_addr[w0], 16'h0010);
    check(cap_data[w0] == 8'h5A, "R9 data", cap_data[w0], 8'h5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    tick(4*H);
    t_single();
    t_poll();
    t_mismatch();
    t_page();
    t_rstart();
    tick(4*H);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule